// File: doc/BRIEF.md
# Programmable 16-bit Event Counter Channel

This block is one channel of a general-purpose counter. Software programs it through three registers on a small read/write port: the live count, a compare value and a configuration word. Each clock cycle the channel may advance. What advances it is chosen by the configuration: every system clock, every eighth system clock, or a strobe from outside the block, such as a pixel-clock tick or the start of a line blank. A sync input that follows the horizontal blanking interval can pause the count, clear it, or hold it until the first blank arrives.

The count wraps either at its maximum or, when selected, just after it matches the compare value. Each wrap raises a sticky status bit. A status bit stays set until software reads the configuration word. Either kind of wrap can raise an active-low interrupt line. That line can be a fixed-length low pulse or a level that flips on each event. It can fire on every event or only once per configuration write. A parameter selects how the sync input is read. On the line-blank variant the input is used as a blank level. On the free-running variant the sync modes only gate the count and ignore the blank input.

Top module: `root_counter_chan`

## Requirements
- R1: After reset the count reads 0, the compare value reads 0 and the configuration word (register index 1) reads 0x0400.
- R2: Configuration bits 9:8 pick the advance source: 00 advances every cycle, 01 advances on each cycle with `ext_tick` high, 10 or 11 advances once per eight cycles. The first of these advances comes eight cycles after the configuration write.
- R3: A write to the configuration word (index 1) zeroes the count. A write to the count register (index 0) loads the written value. Register index 2 holds the compare value.
- R4: With bit 3 set, an advance taken while the count equals the compare value returns the count to 0 and sets status bit 11. Status bit 12 is never set in this case.
- R5: With bit 3 clear, an advance from 0xFFFF wraps the count to 0 and sets status bit 12.
- R6: Status bits 11 and 12 stay set until a read of the configuration word (`rd_en` high at index 1). That read returns the bits and clears them. An event in the same cycle as the read leaves its bit set.
- R7: On the free-running variant with bit 0 set, sync modes 0 and 3 (bits 2:1) freeze the count and modes 1 and 2 let it advance.
- R8: On the line-blank variant with bit 0 set, each sync mode acts as follows. Mode 0 advances only while `hblank` is low. Mode 1 zeroes the count on each rising edge of `hblank`. Mode 2 zeroes on each rising edge and advances only while `hblank` is high. Mode 3 holds the count until the first rising edge and then advances freely.
- R9: `irq_n` is active low and is mirrored in configuration bit 10. Bit 4 enables a request on a compare event and bit 5 enables a request on a maximum wrap.
- R10: With bit 7 clear, a request drives `irq_n` low for PULSE_CYCLES cycles, after which it returns high.
- R11: With bit 7 set, each request inverts `irq_n`, and the level persists until the next request.
- R12: With bit 6 set, every qualifying event requests. With bit 6 clear, only the first one after a configuration write does.
- R13: A configuration write drives `irq_n` high and re-arms the single-shot request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears status when reading the configuration word |
| addr | input | 2 | Register index: 0 count, 1 configuration, 2 compare |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the indexed register (combinational) |
| ext_tick | input | 1 | External advance strobe, one cycle per event |
| hblank | input | 1 | Horizontal blanking level |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The critical case is a status-clearing read of the configuration word that lands in the same cycle as a compare event. If the clear took priority, the hit would be lost. The bench sets a compare value of 3 and places the read on exactly the edge where the count leaves 3. The value returned by that read must show the bit clear, and the next read must show it set. The bench also checks the case where a configuration write collides with counting: the count must restart from zero rather than advance.

// File: rtl/rc_pkg.sv
package rc_pkg;

    // Register indices on the access port.
    typedef enum logic [1:0] {
        REG_VALUE  = 2'd0,
        REG_MODE   = 2'd1,
        REG_TARGET = 2'd2
    } reg_sel_e;

    // Which sync input semantics the channel uses.
    typedef enum logic {
        SYNC_HBLANK = 1'b0,
        SYNC_SYSCLK = 1'b1
    } sync_kind_e;

    // Writable configuration, bits 9:0 of the configuration word.
    typedef struct packed {
        logic [1:0] clk_sel;    // 9:8
        logic       toggle;     // 7
        logic       rpt;        // 6
        logic       irq_ovf;    // 5
        logic       irq_tgt;    // 4
        logic       rst_tgt;    // 3
        logic [1:0] sync_mode;  // 2:1
        logic       sync_en;    // 0
    } mode_cfg_t;

    localparam int CFG_W = $bits(mode_cfg_t);

    // Assemble the readable configuration word.
    function automatic logic [15:0] status_word(mode_cfg_t c, logic irqn,
                                                logic ft, logic fo);
        return {3'b000, fo, ft, irqn, c};
    endfunction

endpackage

// File: rtl/rc_prescaler.sv
module rc_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) phase_q <= '0;
        else if (tick)      phase_q <= '0;
        else                phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/rc_sync_gate.sv
module rc_sync_gate
    import rc_pkg::*;
#(
    parameter sync_kind_e KIND = SYNC_HBLANK
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       sync_en,
    input  logic [1:0] sync_mode,
    input  logic       hblank,
    output logic       run,
    output logic       zero
);
    logic hb_q;
    logic seen_q;
    logic rise;

    assign rise = hblank && !hb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_q   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            hb_q <= hblank;
            if (restart)   seen_q <= 1'b0;
            else if (rise) seen_q <= 1'b1;
        end
    end

    always_comb begin
        run  = 1'b1;
        zero = 1'b0;
        if (sync_en) begin
            if (KIND == SYNC_SYSCLK) begin
                run = (sync_mode == 2'd1) || (sync_mode == 2'd2);
            end else begin
                unique case (sync_mode)
                    2'd0: run = !hblank;
                    2'd1: zero = rise;
                    2'd2: begin
                        run  = hblank;
                        zero = rise;
                    end
                    default: run = seen_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/rc_irq_gen.sv
module rc_irq_gen #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rearm,
    input  logic fire,
    input  logic toggle,
    input  logic rpt,
    output logic irq_n,
    output logic armed
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [PW-1:0] HOLD = PW'(PULSE_CYCLES - 1);

    logic [PW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            irq_n  <= 1'b1;
            armed  <= 1'b1;
            hold_q <= '0;
        end else if (fire && armed) begin
            armed <= rpt;
            if (toggle) begin
                irq_n  <= !irq_n;
                hold_q <= '0;
            end else begin
                irq_n  <= 1'b0;
                hold_q <= HOLD;
            end
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end else if (!irq_n && !toggle) begin
            irq_n <= 1'b1;
        end
    end
endmodule

// File: rtl/root_counter_chan.sv
module root_counter_chan
    import rc_pkg::*;
#(
    parameter int         DATA_W       = 16,
    parameter int         PRESCALE     = 8,
    parameter int         PULSE_CYCLES = 4,
    parameter sync_kind_e SYNC_KIND    = SYNC_HBLANK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ext_tick,
    input  logic              hblank,
    output logic              irq_n
);
    mode_cfg_t         cfg_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] tgt_q;
    logic              flag_tgt_q;
    logic              flag_ovf_q;

    logic mode_wr, value_wr, target_wr, mode_rd;
    logic div_tick, src_tick;
    logic gate_run, gate_zero;
    logic cnt_step, tgt_evt, ovf_evt, irq_fire, irq_armed;

    assign mode_wr   = wr_en && (addr == REG_MODE);
    assign value_wr  = wr_en && (addr == REG_VALUE);
    assign target_wr = wr_en && (addr == REG_TARGET);
    assign mode_rd   = rd_en && (addr == REG_MODE);

    rc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (mode_wr),
        .tick    (div_tick)
    );

    rc_sync_gate #(.KIND(SYNC_KIND)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .restart   (mode_wr),
        .sync_en   (cfg_q.sync_en),
        .sync_mode (cfg_q.sync_mode),
        .hblank    (hblank),
        .run       (gate_run),
        .zero      (gate_zero)
    );

    always_comb begin
        unique case (cfg_q.clk_sel)
            2'b00:   src_tick = 1'b1;
            2'b01:   src_tick = ext_tick;
            default: src_tick = div_tick;
        endcase
    end

    // Register writes and sync clears take the cycle; no event is raised then.
    assign cnt_step = src_tick && gate_run && !mode_wr && !value_wr && !gate_zero;
    assign tgt_evt  = cnt_step && (cnt_q == tgt_q);
    assign ovf_evt  = cnt_step && (&cnt_q) && !cfg_q.rst_tgt;
    assign irq_fire = (tgt_evt && cfg_q.irq_tgt) || (ovf_evt && cfg_q.irq_ovf);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (mode_wr || gate_zero) begin
            cnt_q <= '0;
        end else if (value_wr) begin
            cnt_q <= wdata;
        end else if (cnt_step) begin
            if (tgt_evt && cfg_q.rst_tgt) cnt_q <= '0;
            else                          cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            tgt_q <= '0;
        end else begin
            if (mode_wr)   cfg_q <= mode_cfg_t'(wdata[CFG_W-1:0]);
            if (target_wr) tgt_q <= wdata;
        end
    end

    // Status bits: a clearing read loses to a same-cycle event.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_tgt_q <= 1'b0;
            flag_ovf_q <= 1'b0;
        end else if (mode_rd) begin
            flag_tgt_q <= tgt_evt;
            flag_ovf_q <= ovf_evt;
        end else begin
            flag_tgt_q <= flag_tgt_q || tgt_evt;
            flag_ovf_q <= flag_ovf_q || ovf_evt;
        end
    end

    rc_irq_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .rearm  (mode_wr),
        .fire   (irq_fire),
        .toggle (cfg_q.toggle),
        .rpt    (cfg_q.rpt),
        .irq_n  (irq_n),
        .armed  (irq_armed)
    );

    always_comb begin
        unique case (addr)
            REG_VALUE:  rdata = cnt_q;
            REG_MODE:   rdata = DATA_W'(status_word(cfg_q, irq_n, flag_tgt_q, flag_ovf_q));
            REG_TARGET: rdata = tgt_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/rc_checker.sv
module rc_checker
    import rc_pkg::*;
#(
    parameter int         DATA_W = 16,
    parameter sync_kind_e KIND   = SYNC_HBLANK
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cnt,
    input mode_cfg_t         cfg,
    input logic              flag_tgt,
    input logic              tgt_evt,
    input logic              ovf_evt,
    input logic              irq_n,
    input logic              armed
);
    logic mwr;
    assign mwr = wr_en && (addr == REG_MODE);

    p_mode_wr_zero_r3: assert property (@(posedge clk) disable iff (rst)
        mwr |=> (cnt == '0));

    p_value_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_VALUE) |=> (cnt == $past(wdata)));

    p_no_ovf_on_tgt_reset_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> !cfg.rst_tgt);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_MODE && !tgt_evt) |=> !flag_tgt);

    p_irq_fires_r9: assert property (@(posedge clk) disable iff (rst)
        (tgt_evt && cfg.irq_tgt && armed && !cfg.toggle) |=> !irq_n);

    p_oneshot_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!armed && cfg.toggle && !mwr) |=> $stable(irq_n));

    p_rearm_r13: assert property (@(posedge clk) disable iff (rst)
        mwr |=> (irq_n && armed));

    generate
        if (KIND == SYNC_SYSCLK) begin : g_sys
            p_sys_halt_r7: assert property (@(posedge clk) disable iff (rst)
                (cfg.sync_en && (cfg.sync_mode == 2'd0 || cfg.sync_mode == 2'd3) && !wr_en)
                |=> $stable(cnt));
        end
    endgenerate
endmodule

bind root_counter_chan rc_checker #(.DATA_W(DATA_W), .KIND(SYNC_KIND)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .cnt      (cnt_q),
    .cfg      (cfg_q),
    .flag_tgt (flag_tgt_q),
    .tgt_evt  (tgt_evt),
    .ovf_evt  (ovf_evt),
    .irq_n    (irq_n),
    .armed    (irq_armed)
);

// File: tb/tb_root_counter_chan.sv
module tb_root_counter_chan;
    import rc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, rdata_sys;
    logic        ext_tick = 1'b0, hblank = 1'b0;
    logic        irq_n, irq_n_sys;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = !clk;

    root_counter_chan #(.SYNC_KIND(SYNC_HBLANK)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .hblank(hblank),
        .irq_n(irq_n));

    root_counter_chan #(.SYNC_KIND(SYNC_SYSCLK)) dut_sys (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_sys), .ext_tick(ext_tick), .hblank(hblank),
        .irq_n(irq_n_sys));

    typedef struct packed {
        logic        sel;     // 0: line-blank channel, 1: free-running channel
        logic [15:0] mode;
        logic [15:0] tgt;
        logic [15:0] cycles;
        logic [15:0] expv;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 16'h0000, 16'h0000, 16'd20, 16'd20, 4'd2},  // R2 every cycle
        '{1'b0, 16'h0200, 16'h0000, 16'd80, 16'd10, 4'd2},  // R2 divide by eight
        '{1'b0, 16'h0300, 16'h0000, 16'd43, 16'd5,  4'd2},  // R2 divide, partial
        '{1'b0, 16'h0008, 16'h0005, 16'd13, 16'd1,  4'd4},  // R4 wrap at compare
        '{1'b0, 16'h0008, 16'h0005, 16'd6,  16'd0,  4'd4},  // R4 exact wrap
        '{1'b1, 16'h0001, 16'h0000, 16'd9,  16'd0,  4'd7},  // R7 mode 0 halts
        '{1'b1, 16'h0003, 16'h0000, 16'd9,  16'd9,  4'd7},  // R7 mode 1 runs
        '{1'b1, 16'h0005, 16'h0000, 16'd9,  16'd9,  4'd7},  // R7 mode 2 runs
        '{1'b1, 16'h0007, 16'h0000, 16'd9,  16'd0,  4'd7}   // R7 mode 3 halts
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v, output logic [15:0] vs);
        addr = a;
        #1;
        v = rdata;
        vs = rdata_sys;
    endtask

    task automatic rd_mode(output logic [15:0] v);
        addr = REG_MODE; rd_en = 1'b1;
        #1;
        v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: all requirements, actual hung expected done");
            report();
        end
    end

    initial begin
        logic [15:0] v, vs;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(REG_VALUE, v, vs);  check("R1 count", v, 16'h0000);
        peek(REG_TARGET, v, vs); check("R1 compare", v, 16'h0000);
        peek(REG_MODE, v, vs);   check("R1 config", v, 16'h0400);

        // Vector table: compare write, configuration write, wait, sample count
        for (int i = 0; i < NROWS; i++) begin
            wr(REG_TARGET, ROWS[i].tgt);
            wr(REG_MODE, ROWS[i].mode);
            idle(int'(ROWS[i].cycles));
            peek(REG_VALUE, v, vs);
            n_chk++;
            if ((ROWS[i].sel ? vs : v) !== ROWS[i].expv) begin
                n_bad++;
                $display("FAIL R%0d table row %0d: actual %h expected %h",
                         ROWS[i].req, i, (ROWS[i].sel ? vs : v), ROWS[i].expv);
            end
        end

        // R2 external strobe: five high cycles
        wr(REG_MODE, 16'h0100);
        for (int i = 0; i < 10; i++) begin
            ext_tick = (i % 2 == 0);
            @(negedge clk);
        end
        ext_tick = 1'b0;
        peek(REG_VALUE, v, vs); check("R2 external", v, 16'd5);

        // R4 and R6: compare wrap sets bit 11 only; a second read shows it clear
        wr(REG_TARGET, 16'd5);
        wr(REG_MODE, 16'h0008);
        rd_mode(v);
        idle(12);
        rd_mode(v);
        check("R4 target flag", {15'd0, v[11]}, 16'd1);
        check("R4 no overflow flag", {15'd0, v[12]}, 16'd0);
        rd_mode(v);
        check("R6 cleared after read", {15'd0, v[11]}, 16'd0);

        // R3 and R5: load near maximum, wrap sets bit 12
        wr(REG_MODE, 16'h0000);
        rd_mode(v);
        wr(REG_VALUE, 16'hFFF0);
        peek(REG_VALUE, v, vs); check("R3 value load", v, 16'hFFF0);
        idle(15);
        peek(REG_VALUE, v, vs); check("R5 at max", v, 16'hFFFF);
        idle(1);
        peek(REG_VALUE, v, vs); check("R5 wrapped", v, 16'h0000);
        rd_mode(v);
        check("R5 overflow flag", {15'd0, v[12]}, 16'd1);
        check("R5 no target flag", {15'd0, v[11]}, 16'd0);
        wr(REG_VALUE, 16'h0040);
        wr(REG_MODE, 16'h0000);
        peek(REG_VALUE, v, vs); check("R3 config write zeroes", v, 16'h0000);

        // R6 coincidence: clearing read on the compare-event edge
        wr(REG_TARGET, 16'd3);
        wr(REG_MODE, 16'h0008);
        rd_mode(v);
        idle(2);
        rd_mode(v);
        check("R6 read on event edge returns clear", {15'd0, v[11]}, 16'd0);
        rd_mode(v);
        check("R6 event survives clear", {15'd0, v[11]}, 16'd1);

        // R8 line-blank channel, mode 0
        hblank = 1'b1;
        wr(REG_MODE, 16'h0001);
        idle(5);
        peek(REG_VALUE, v, vs); check("R8 mode0 paused in blank", v, 16'd0);
        hblank = 1'b0;
        idle(4);
        peek(REG_VALUE, v, vs); check("R8 mode0 counts outside", v, 16'd4);
        // mode 1
        wr(REG_MODE, 16'h0003);
        idle(7);
        peek(REG_VALUE, v, vs); check("R8 mode1 counts", v, 16'd7);
        hblank = 1'b1;
        idle(1);
        peek(REG_VALUE, v, vs); check("R8 mode1 zero at edge", v, 16'd0);
        idle(3);
        peek(REG_VALUE, v, vs); check("R8 mode1 runs in blank", v, 16'd3);
        hblank = 1'b0;
        // mode 2
        wr(REG_MODE, 16'h0005);
        idle(5);
        peek(REG_VALUE, v, vs); check("R8 mode2 paused outside", v, 16'd0);
        hblank = 1'b1;
        idle(4);
        peek(REG_VALUE, v, vs); check("R8 mode2 zero then count", v, 16'd3);
        hblank = 1'b0;
        idle(3);
        peek(REG_VALUE, v, vs); check("R8 mode2 holds outside", v, 16'd3);
        // mode 3
        wr(REG_MODE, 16'h0007);
        idle(5);
        peek(REG_VALUE, v, vs); check("R8 mode3 waits", v, 16'd0);
        hblank = 1'b1;
        idle(5);
        peek(REG_VALUE, v, vs); check("R8 mode3 starts after edge", v, 16'd4);
        hblank = 1'b0;
        idle(3);
        peek(REG_VALUE, v, vs); check("R8 mode3 free", v, 16'd7);

        // R9 R10 R12: pulse, repeating, compare 9 (events every ten cycles)
        wr(REG_TARGET, 16'd9);
        wr(REG_MODE, 16'h0058);
        idle(10);
        check("R9 pulse low", {15'd0, irq_n}, 16'd0);
        peek(REG_MODE, v, vs); check("R9 bit10 mirrors line", {15'd0, v[10]}, 16'd0);
        idle(4);
        check("R10 pulse released", {15'd0, irq_n}, 16'd1);
        idle(6);
        check("R12 repeat fires again", {15'd0, irq_n}, 16'd0);

        // R12 one-shot pulse
        wr(REG_MODE, 16'h0018);
        idle(10);
        check("R12 one-shot first", {15'd0, irq_n}, 16'd0);
        idle(10);
        check("R12 one-shot ignores second", {15'd0, irq_n}, 16'd1);

        // R11 toggle, repeating
        wr(REG_MODE, 16'h00D8);
        idle(10);
        check("R11 toggle first", {15'd0, irq_n}, 16'd0);
        idle(5);
        check("R11 toggle holds", {15'd0, irq_n}, 16'd0);
        idle(5);
        check("R11 toggle second", {15'd0, irq_n}, 16'd1);

        // R12 toggle one-shot then R13 rearm
        wr(REG_MODE, 16'h0098);
        idle(20);
        check("R12 toggle one-shot stays", {15'd0, irq_n}, 16'd0);
        wr(REG_MODE, 16'h0098);
        check("R13 config write releases", {15'd0, irq_n}, 16'd1);
        idle(10);
        check("R13 rearmed fires", {15'd0, irq_n}, 16'd0);

        // R9 request on maximum wrap
        wr(REG_MODE, 16'h0060);
        wr(REG_VALUE, 16'hFFFD);
        idle(3);
        check("R9 overflow request", {15'd0, irq_n}, 16'd0);

        done = 1;
        report();
    end
endmodule